// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two 16-bit timer/counters behind a small byte-wide register interface: a control byte with a run bit and an overflow flag per timer, and a mode byte with four configuration bits per timer (gate, counter select and two mode bits). Each timer advances either on a prescaled internal tick, at one step per 12 or per 4 system clocks, or on falling edges of its own external count pin. An external gate pin can hold a timer until the pin is high.

Four counting shapes are available: a 13-bit timer, a plain 16-bit timer, an 8-bit timer that reloads itself, and a split arrangement. In the split arrangement timer 0 becomes two independent 8-bit counters, while timer 1 in that mode simply holds. Overflows set flags that serve as interrupt requests. An acknowledge from the interrupt controller clears a flag, and software may write a flag either way. Each timer can also drive a toggle output that flips on every overflow, so the output runs at half the overflow rate.

Software writes the registers through a single write strobe with a 3-bit address. The counts, the control byte and the mode byte are visible on output ports.

Top module: `tmr_pair`

## Requirements
- R1: After synchronous reset all counts, flags, run bits, mode bits, prescale selects, toggle enables and toggle outputs are zero.
- R2: Write address 0 is the control byte, with bit 7 TF1, bit 6 TR1, bit 5 TF0, bit 4 TR0, and bits 3..0 reading 0. Address 1 is the mode byte: timer 1 in bits 7..4 and timer 0 in bits 3..0, each nibble ordered gate, counter-select, mode high, mode low. Addresses 2, 3, 4 and 5 are the low and high count bytes of timer 0 and then of timer 1. Address 6 is the aux byte: bits 0 and 1 choose the fast prescale for timer 0 and timer 1, and bits 2 and 3 enable the toggle outputs of timer 0 and timer 1. The count ports read {high, low}.
- R3: In timer mode a running timer advances exactly once per 12 clocks when its prescale bit is 0, and once per 4 clocks when it is 1. It never moves more than one step in a cycle.
- R4: Mode 0 is 13 bits wide. Bits 4..0 of the low byte prescale the high byte, bits 7..5 of the low byte are left unchanged, and a carry out of the high byte is an overflow.
- R5: Mode 1 is a 16-bit up counter. It wraps from FFFF to 0000 and signals an overflow.
- R6: Mode 2 counts the low byte. On a step at FF the low byte reloads from the high byte and an overflow is signalled.
- R7: With timer 0 in mode 3, its low byte counts under timer 0's controls and sets TF0. Its high byte counts prescaled ticks, using timer 0's prescale select, whenever TR1 is set, and its overflow sets TF1. Timer 1 in mode 3 holds its count.
- R8: With the gate bit set, a timer advances only while its gate pin, after synchronization, is high and its run bit is set.
- R9: With counter-select set, each falling edge on the count pin advances the timer by one step, and rising edges have no effect. The pin passes through two synchronizer flops and an edge-compare flop, so the count moves on the third rising clock edge after the pin falls.
- R10: A flag is set by an overflow and cleared by its acknowledge input. A set in the same cycle beats an acknowledge, and a control-byte write beats both.
- R11: When its toggle enable is set, a timer's toggle output inverts on every overflow of that timer. When the enable is clear, the output holds.
- R12: A software write to a count byte takes priority over an increment of that byte in the same cycle.
- R13: A timer whose run bit is clear holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (see R2) |
| wr_data | input | 8 | Write data |
| ack | input | 2 | Interrupt acknowledge per timer, clears the flag |
| cnt_pin | input | 2 | External count inputs, falling edge counts |
| gate_pin | input | 2 | External gate inputs, high enables when gated |
| ctrl_q | output | 8 | Control byte readback |
| mode_q | output | 8 | Mode byte readback |
| cnt0_q | output | 16 | Timer 0 count {high, low} |
| cnt1_q | output | 16 | Timer 1 count {high, low} |
| irq | output | 2 | Overflow interrupt requests (flags TF1, TF0) |
| tog_q | output | 2 | Overflow toggle outputs |

## Verification
The bench builds the block with its default dividers of 12 and 4 and two synchronizer stages. Because the dividers are this small, counting windows of a few dozen cycles can be swept one length after another, and exactly one tick falls in every divider period whatever the phase. Every overflow path, including the 13-bit carry, the reload and both split halves, is reached in a handful of ticks by preloading counts just below their terminal value. With two synchronizer stages, pin edges settle within five cycles, so gate and edge-count behaviour is checked in short windows.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W  = 8;
    localparam int TR0_BIT = 4;
    localparam int TF0_BIT = 5;

    typedef enum logic [1:0] {
        MD_13BIT  = 2'b00,
        MD_16BIT  = 2'b01,
        MD_RELOAD = 2'b10,
        MD_SPLIT  = 2'b11
    } tmr_mode_e;

    // nibble layout: gate, counter select, mode[1:0]
    typedef struct packed {
        logic      gate;
        logic      cnt_sel;
        tmr_mode_e mode;
    } tmr_cfg_t;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_MODE = 3'd1,
        RA_LO0  = 3'd2,
        RA_HI0  = 3'd3,
        RA_LO1  = 3'd4,
        RA_HI1  = 3'd5,
        RA_AUX  = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/tmr_div.sv
module tmr_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int SPLIT_OK = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_mode_e         mode,
    input  logic              step,
    input  logic              step_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [15:0]       cnt_q,
    output logic              ovf,
    output logic              ovf_hi
);
    logic [BYTE_W-1:0] lo, hi, lo_n, hi_n;

    always_comb begin
        lo_n   = lo;
        hi_n   = hi;
        ovf    = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            MD_13BIT: if (step) begin
                lo_n[4:0] = lo[4:0] + 5'd1;
                if (lo[4:0] == 5'h1F) begin
                    hi_n = hi + 8'd1;
                    ovf  = (hi == 8'hFF);
                end
            end
            MD_16BIT: if (step) begin
                {hi_n, lo_n} = {hi, lo} + 16'd1;
                ovf          = ({hi, lo} == 16'hFFFF);
            end
            MD_RELOAD: if (step) begin
                if (lo == 8'hFF) begin
                    lo_n = hi;
                    ovf  = 1'b1;
                end else begin
                    lo_n = lo + 8'd1;
                end
            end
            MD_SPLIT: if (SPLIT_OK != 0) begin
                if (step) begin
                    lo_n = lo + 8'd1;
                    ovf  = (lo == 8'hFF);
                end
                if (step_hi) begin
                    hi_n   = hi + 8'd1;
                    ovf_hi = (hi == 8'hFF);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= wr_lo ? wr_data : lo_n;
            hi <= wr_hi ? wr_data : hi_n;
        end
    end

    assign cnt_q = {hi, lo};
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  ack,
    input  logic [1:0]  cnt_pin,
    input  logic [1:0]  gate_pin,
    output logic [7:0]  ctrl_q,
    output logic [7:0]  mode_q,
    output logic [15:0] cnt0_q,
    output logic [15:0] cnt1_q,
    output logic [1:0]  irq,
    output logic [1:0]  tog_q
);
    localparam int NT = 2;

    logic tick_slow, tick_fast;
    tmr_div #(.DIV(DIV_SLOW)) u_div_slow (.clk(clk), .rst(rst), .tick(tick_slow));
    tmr_div #(.DIV(DIV_FAST)) u_div_fast (.clk(clk), .rst(rst), .tick(tick_fast));

    logic          wr_ctrl, wr_mode, wr_aux;
    logic [NT-1:0] wr_lo, wr_hi;
    assign wr_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign wr_mode  = wr_en && (wr_addr == RA_MODE);
    assign wr_aux   = wr_en && (wr_addr == RA_AUX);
    assign wr_lo[0] = wr_en && (wr_addr == RA_LO0);
    assign wr_hi[0] = wr_en && (wr_addr == RA_HI0);
    assign wr_lo[1] = wr_en && (wr_addr == RA_LO1);
    assign wr_hi[1] = wr_en && (wr_addr == RA_HI1);

    logic [NT-1:0] tf, tr, fast_sel, tog_en, en, step, fall;
    logic [NT-1:0] gate_s, cnt_s, cnt_d, ovf, ovf_hi, set_tf;
    tmr_cfg_t      cfg [NT];
    logic [15:0]   cnt [NT];

    // split mode: high byte of timer 0 runs from TR1 and owns TF1
    logic split0, step_hi0;
    assign split0   = (cfg[0].mode == MD_SPLIT);
    assign step_hi0 = tr[1] & (fast_sel[0] ? tick_fast : tick_slow);
    assign set_tf[0] = ovf[0];
    assign set_tf[1] = split0 ? ovf_hi[0] : (ovf[1] | ovf_hi[1]);

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        tmr_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
            .clk(clk), .rst(rst), .d(cnt_pin[i]), .q(cnt_s[i]));
        tmr_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
            .clk(clk), .rst(rst), .d(gate_pin[i]), .q(gate_s[i]));

        assign fall[i] = cnt_d[i] & ~cnt_s[i];
        assign en[i]   = tr[i] & (~cfg[i].gate | gate_s[i]);
        assign step[i] = en[i] & (cfg[i].cnt_sel ? fall[i]
                                 : (fast_sel[i] ? tick_fast : tick_slow));

        tmr_core #(.SPLIT_OK(i == 0 ? 1 : 0)) u_core (
            .clk     (clk),
            .rst     (rst),
            .mode    (cfg[i].mode),
            .step    (step[i]),
            .step_hi ((i == 0) ? step_hi0 : 1'b0),
            .wr_lo   (wr_lo[i]),
            .wr_hi   (wr_hi[i]),
            .wr_data (wr_data),
            .cnt_q   (cnt[i]),
            .ovf     (ovf[i]),
            .ovf_hi  (ovf_hi[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tf       <= '0;
            tr       <= '0;
            fast_sel <= '0;
            tog_en   <= '0;
            tog_q    <= '0;
            cnt_d    <= '0;
            cfg[0]   <= '0;
            cfg[1]   <= '0;
        end else begin
            cnt_d <= cnt_s;
            for (int i = 0; i < NT; i++) begin
                if (wr_ctrl) begin
                    tf[i] <= wr_data[TF0_BIT + 2*i];
                    tr[i] <= wr_data[TR0_BIT + 2*i];
                end else if (set_tf[i]) begin
                    tf[i] <= 1'b1;
                end else if (ack[i]) begin
                    tf[i] <= 1'b0;
                end
                if (wr_mode) cfg[i] <= tmr_cfg_t'(wr_data[4*i +: 4]);
                if (wr_aux) begin
                    fast_sel[i] <= wr_data[i];
                    tog_en[i]   <= wr_data[2 + i];
                end
                if (tog_en[i] && ovf[i]) tog_q[i] <= ~tog_q[i];
            end
        end
    end

    assign ctrl_q = {tf[1], tr[1], tf[0], tr[0], 4'b0000};
    assign mode_q = {cfg[1], cfg[0]};
    assign cnt0_q = cnt[0];
    assign cnt1_q = cnt[1];
    assign irq    = tf;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic [7:0]  ctrl_q,
    input logic [7:0]  mode_q,
    input logic [15:0] cnt0_q,
    input logic [15:0] cnt1_q,
    input logic [1:0]  irq,
    input logic [1:0]  tog_q,
    input logic        ovf0
);
    logic wr_t0, wr_t1;
    assign wr_t0 = wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3);
    assign wr_t1 = wr_en && (wr_addr == 3'd4 || wr_addr == 3'd5);

    p_tf_set_r10: assert property (@(posedge clk) disable iff (rst)
        (ovf0 && !(wr_en && wr_addr == 3'd0)) |=> irq[0]);

    p_halt_t1_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_q[5:4] == 2'b11 && !wr_t1) |=> $stable(cnt1_q));

    p_hold_stopped_r13: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[4] && mode_q[1:0] != 2'b11 && !wr_t0) |=> $stable(cnt0_q));

    p_tog_only_ovf_r11: assert property (@(posedge clk) disable iff (rst)
        !ovf0 |=> $stable(tog_q[0]));

    p_single_step_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q[1:0] == 2'b01 && !wr_t0)
        |=> (cnt0_q == $past(cnt0_q) || cnt0_q == $past(cnt0_q) + 16'd1));

    p_wr_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd2) |=> (cnt0_q[7:0] == $past(wr_data)));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .mode_q(mode_q), .cnt0_q(cnt0_q), .cnt1_q(cnt1_q),
    .irq(irq), .tog_q(tog_q), .ovf0(ovf[0])
);

// File: tb/tmr_pair_test.sv
`timescale 1ns/1ps
module tmr_pair_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [7:0]  wr_data;
    logic [1:0]  ack, cnt_pin, gate_pin;
    logic [7:0]  ctrl_q, mode_q;
    logic [15:0] cnt0_q, cnt1_q;
    logic [1:0]  irq, tog_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] s0, s1;

    localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_LO0 = 3'd2,
                           A_HI0 = 3'd3, A_LO1 = 3'd4, A_HI1 = 3'd5, A_AUX = 3'd6;

    always #2.5 clk = ~clk;

    tmr_pair uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ack(ack), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
        .ctrl_q(ctrl_q), .mode_q(mode_q), .cnt0_q(cnt0_q), .cnt1_q(cnt1_q),
        .irq(irq), .tog_q(tog_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        cnt_pin[idx] = 1'b1; cyc(3);
        cnt_pin[idx] = 1'b0; cyc(3);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        ack = '0; cnt_pin = '0; gate_pin = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        chk("R1 ctrl", ctrl_q, 0);
        chk("R1 mode", mode_q, 0);
        chk("R1 cnt0", cnt0_q, 0);
        chk("R1 cnt1", cnt1_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tog", tog_q, 0);

        // R2 register map, R3 slow prescale on both timers
        wr(A_MODE, 8'h11);
        wr(A_CTRL, 8'h50);
        chk("R2 ctrl readback", ctrl_q, 8'h50);
        chk("R2 mode readback", mode_q, 8'h11);
        s0 = cnt0_q; s1 = cnt1_q;
        cyc(60);
        chk("R3 slow t0", 16'(cnt0_q - s0), 5);
        chk("R3 slow t1", 16'(cnt1_q - s1), 5);

        // R3 fast prescale on timer 0 only
        wr(A_AUX, 8'h01);
        s0 = cnt0_q; s1 = cnt1_q;
        cyc(60);
        chk("R3 fast t0", 16'(cnt0_q - s0), 15);
        chk("R3 slow t1 kept", 16'(cnt1_q - s1), 5);
        for (int k = 1; k <= 6; k++) begin
            s0 = cnt0_q;
            cyc(4 * k);
            chk("R3 fast window", 16'(cnt0_q - s0), k);
        end

        // R13 stopped timers hold
        wr(A_CTRL, 8'h00);
        s0 = cnt0_q; s1 = cnt1_q;
        cyc(30);
        chk("R13 t0 hold", cnt0_q, s0);
        chk("R13 t1 hold", cnt1_q, s1);

        // R5 16-bit wrap and flag
        wr(A_LO0, 8'hFE); wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h10);
        cyc(12);
        chk("R5 wrap", cnt0_q, 16'h0001);
        chk("R5 TF0", irq, 2'b01);
        chk("R2 TF0 bit", ctrl_q, 8'h30);

        // R10 ack clears, software write either way
        ack = 2'b01; cyc(1); ack = 2'b00;
        chk("R10 ack clears", irq[0], 1'b0);
        wr(A_CTRL, 8'h30);
        chk("R10 sw set", irq[0], 1'b1);
        wr(A_CTRL, 8'h10);
        chk("R10 sw clear", irq[0], 1'b0);

        // R4 13-bit mode: carry, overflow, upper low-byte bits kept
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h10);
        wr(A_LO0, 8'h1E); wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h10);
        cyc(12);
        chk("R4 overflow value", cnt0_q, 16'h0001);
        chk("R4 overflow flag", irq[0], 1'b1);
        wr(A_CTRL, 8'h00);
        wr(A_LO0, 8'hFD); wr(A_HI0, 8'h12);
        wr(A_CTRL, 8'h10);
        cyc(12);
        chk("R4 carry keeps bits 7..5", cnt0_q, 16'h13E0);
        chk("R4 no flag", irq[0], 1'b0);

        // R6 reload mode
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h12);
        wr(A_LO0, 8'hFE); wr(A_HI0, 8'h80);
        wr(A_CTRL, 8'h10);
        cyc(12);
        chk("R6 reload", cnt0_q, 16'h8081);
        chk("R6 flag", irq[0], 1'b1);

        // R11 toggle output
        wr(A_CTRL, 8'h00);
        wr(A_AUX, 8'h05);
        wr(A_MODE, 8'h11);
        wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h10);
        cyc(4);
        chk("R11 toggled", tog_q, 2'b01);
        cyc(8);
        chk("R11 steady", tog_q, 2'b01);
        wr(A_CTRL, 8'h00);
        wr(A_AUX, 8'h01);
        wr(A_LO0, 8'hFF); wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h10);
        cyc(4);
        chk("R11 disabled holds", tog_q, 2'b01);
        chk("R11 overflow seen", irq[0], 1'b1);

        // R8 gate
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h19);
        wr(A_CTRL, 8'h10);
        cyc(5);
        s0 = cnt0_q; cyc(24);
        chk("R8 gate low blocks", 16'(cnt0_q - s0), 0);
        gate_pin[0] = 1'b1; cyc(5);
        s0 = cnt0_q; cyc(24);
        chk("R8 gate high counts", 16'(cnt0_q - s0), 6);
        gate_pin[0] = 1'b0; cyc(5);
        s0 = cnt0_q; cyc(24);
        chk("R8 gate low again", 16'(cnt0_q - s0), 0);

        // R9 edge counting
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h15);
        wr(A_CTRL, 8'h10);
        cyc(5);
        for (int n = 1; n <= 5; n++) begin
            s0 = cnt0_q;
            for (int p = 0; p < n; p++) pulse(0);
            cyc(5);
            chk("R9 falling edges", 16'(cnt0_q - s0), n);
        end
        s0 = cnt0_q;
        cnt_pin[0] = 1'b1; cyc(6);
        chk("R9 rising ignored", 16'(cnt0_q - s0), 0);
        cnt_pin[0] = 1'b0; cyc(2);
        chk("R9 not before third edge", 16'(cnt0_q - s0), 0);
        cyc(1);
        chk("R9 third edge", 16'(cnt0_q - s0), 1);
        wr(A_MODE, 8'h55);
        wr(A_CTRL, 8'h50);
        cyc(5);
        s0 = cnt0_q; s1 = cnt1_q;
        for (int p = 0; p < 4; p++) pulse(1);
        cyc(5);
        chk("R9 t1 edges", 16'(cnt1_q - s1), 4);
        chk("R9 t0 untouched", 16'(cnt0_q - s0), 0);

        // R7 split mode
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h33);
        wr(A_AUX, 8'h01);
        wr(A_LO0, 8'h00); wr(A_HI0, 8'h00);
        s1 = cnt1_q;
        wr(A_CTRL, 8'h40);
        cyc(12);
        chk("R7 high byte on TR1", cnt0_q, 16'h0300);
        chk("R7 t1 halted", cnt1_q, s1);
        wr(A_CTRL, 8'h10);
        s0 = cnt0_q;
        cyc(12);
        chk("R7 low byte on TR0", cnt0_q, 16'(s0 + 16'd3));
        wr(A_CTRL, 8'h00);
        wr(A_HI0, 8'hFF);
        wr(A_CTRL, 8'h40);
        cyc(4);
        chk("R7 high overflow sets TF1", irq, 2'b10);
        wr(A_CTRL, 8'h00);
        wr(A_LO0, 8'hFF);
        wr(A_CTRL, 8'h10);
        cyc(4);
        chk("R7 low overflow sets TF0", irq, 2'b01);

        // R12 write beats increment
        wr(A_CTRL, 8'h00);
        wr(A_MODE, 8'h11);
        wr(A_CTRL, 8'h10);
        wr_en = 1'b1; wr_addr = A_LO0; wr_data = 8'h55;
        cyc(8);
        wr_en = 1'b0;
        chk("R12 write wins", cnt0_q[7:0], 8'h55);

        summary();
        $finish;
    end
endmodule